// File: doc/BRIEF.md
# Four-Level Nesting Interrupt Arbiter

This block chooses which interrupt a small processor should take next and keeps track of how deeply service routines are nested. It has thirteen sources. Each source has an enable bit and a two-bit priority level, and a global enable masks every source. Two of the sources come from active-low external pins. Each pin has its own front end, which either latches a falling edge or passes a low level straight through. The rest of the sources are request lines from inside the chip.

The processor pulses `boundary` at each instruction boundary, and arbitration runs only on that pulse. A winning request is offered on `irq_valid` with `irq_idx` and `irq_level`. The processor takes it by raising `irq_ack`, which works as the ready side of a valid/ready pair. While `irq_valid` is high, the offer does not change and further boundary pulses are ignored. This lasts until the acknowledge. Back-pressure is simply not acknowledging. A one-cycle `reti` pulse marks the return from a service routine. The nesting state is a four-bit in-service mask with one bit per level. It is visible on `in_service`.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset `irq_valid` is 0 and `in_service` is 0000.
- R2: A source can win only while `global_en` is 1 and its own bit in `src_en` is 1. With `global_en` at 0, no grant appears even if enabled sources are pending.
- R3: The level of source i is {`prio_hi[i]`, `prio_lo[i]`}, where 3 is the highest. Among eligible pending sources, the highest level is granted, and `irq_level` reports that level.
- R4: When several eligible sources share the highest level, the one with the lowest index wins.
- R5: A source is eligible only if its level is strictly above the highest level set in `in_service`. A request at an equal or lower level waits.
- R6: While bit 3 of `in_service` is set, no source is granted.
- R7: An acknowledge (`irq_valid` and `irq_ack` both high) sets the `in_service` bit of the granted level. A `reti` pulse clears the highest set bit. When both happen in one cycle, the clear applies to the old mask and then the new bit is set.
- R8: For an external pin i in edge mode (`ext_edge_mode[i]`=1), a request flag is set when one sample taken on `sample_en` is high and the next one is low. Acknowledging source i clears that flag. If a new edge arrives in the same cycle as the acknowledge, the flag stays set.
- R9: For an external pin in level mode, the request is the inverse of the most recent sample. An acknowledge does not clear it.
- R10: A grant is formed only on a cycle with `boundary` high and `irq_valid` low, and only from requests present in that cycle. `irq_valid` rises one cycle later. It then holds, with `irq_idx` and `irq_level` unchanged, until the acknowledge cycle, and it is low on the cycle after that.
- R11: External pin k is source k (k = 0, 1). Internal request bit j of `int_req` is source j+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | Strobe that samples the external pins |
| ext_pin_n | input | 2 | Active-low external interrupt pins |
| ext_edge_mode | input | 2 | Per pin: 1 = falling edge, 0 = low level |
| int_req | input | 11 | Internal request lines, sources 2..12 |
| global_en | input | 1 | Master enable for all sources |
| src_en | input | 13 | Per-source enable |
| prio_lo | input | 13 | Low bit of each source's level |
| prio_hi | input | 13 | High bit of each source's level |
| boundary | input | 1 | Instruction boundary strobe |
| irq_valid | output | 1 | A grant is offered |
| irq_idx | output | 4 | Index of the granted source |
| irq_level | output | 2 | Level of the granted source |
| irq_ack | input | 1 | Processor accepts the offered grant |
| reti | input | 1 | Return from the current service routine |
| in_service | output | 4 | One bit per level that is being serviced |

## Verification
Two pairs of events can land on the same clock edge. An acknowledge can meet a `reti`, and an acknowledge of an edge-triggered pin can meet a fresh falling edge on that same pin. The bench produces the first pair in directed form with a known mask. It also produces it at random, checking the resulting `in_service` against a model that clears the highest bit first and then sets the granted level. For the second pair, the pin sample goes high one cycle and low in the acknowledge cycle. The next boundary must then produce the same source again, and only a later acknowledge with no edge may leave no request behind.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_LEVELS = 4;
  typedef logic [1:0] lvl_t;
  typedef logic [NUM_LEVELS-1:0] lvl_mask_t;
endpackage

// File: rtl/irq_ext_front.sv
module irq_ext_front (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic ack_clr,
  output logic req
);
  logic samp_q;
  logic flag_q;
  logic edge_hit;

  assign edge_hit = sample_en & samp_q & ~pin_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      if (sample_en) samp_q <= pin_n;
      if (!edge_mode)    flag_q <= 1'b0;
      else if (edge_hit) flag_q <= 1'b1;
      else if (ack_clr)  flag_q <= 1'b0;
    end
  end

  assign req = edge_mode ? flag_q : ~samp_q;

  AST_EDGE_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    edge_mode && ack_clr && !edge_hit |=> !flag_q); // R8
  AST_EDGE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    edge_mode && edge_hit |=> flag_q); // R8
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_SRC = 13,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] cand,
  input  logic [NUM_SRC-1:0] lvl_lo,
  input  logic [NUM_SRC-1:0] lvl_hi,
  input  logic               act_any,
  input  irq_pkg::lvl_t      act_lvl,
  output logic               found,
  output logic [IDX_W-1:0]   win_idx,
  output irq_pkg::lvl_t      win_lvl
);
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && (!act_any || ({lvl_hi[i], lvl_lo[i]} > act_lvl))) begin
        if (!found || ({lvl_hi[i], lvl_lo[i]} > win_lvl)) begin
          found   = 1'b1;
          win_idx = IDX_W'(i);
          win_lvl = {lvl_hi[i], lvl_lo[i]};
        end
      end
    end
  end
endmodule

// File: rtl/irq_nest_tracker.sv
module irq_nest_tracker (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  irq_pkg::lvl_t       set_lvl,
  input  logic                clr_en,
  output irq_pkg::lvl_mask_t  isv,
  output logic                any,
  output irq_pkg::lvl_t       top_lvl
);
  import irq_pkg::*;
  lvl_mask_t isv_q;
  lvl_mask_t isv_d;

  always_comb begin
    top_lvl = '0;
    for (int l = 0; l < NUM_LEVELS; l++)
      if (isv_q[l]) top_lvl = lvl_t'(l);
  end

  assign any = |isv_q;

  always_comb begin
    isv_d = isv_q;
    if (clr_en && any) isv_d[top_lvl] = 1'b0;
    if (set_en)        isv_d[set_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isv_q <= '0;
    else        isv_q <= isv_d;
  end

  assign isv = isv_q;

  AST_ACK_SETS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> isv_q[$past(set_lvl)]); // R7
  AST_RETI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en && !set_en && any |=> $countones(isv_q) == $countones($past(isv_q)) - 1); // R7
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NUM_SRC = 13,
  parameter int NUM_EXT = 2,
  localparam int NUM_INT = NUM_SRC - NUM_EXT,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_en,
  input  logic [NUM_EXT-1:0] ext_pin_n,
  input  logic [NUM_EXT-1:0] ext_edge_mode,
  input  logic [NUM_INT-1:0] int_req,
  input  logic               global_en,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic [NUM_SRC-1:0] prio_lo,
  input  logic [NUM_SRC-1:0] prio_hi,
  input  logic               boundary,
  output logic               irq_valid,
  output logic [IDX_W-1:0]   irq_idx,
  output logic [1:0]         irq_level,
  input  logic               irq_ack,
  input  logic               reti,
  output logic [3:0]         in_service
);
  import irq_pkg::*;

  logic [NUM_EXT-1:0] ext_req;
  logic [NUM_SRC-1:0] cand;
  logic               ack_fire;
  logic               found;
  logic [IDX_W-1:0]   win_idx;
  lvl_t               win_lvl;
  logic               act_any;
  lvl_t               act_lvl;
  lvl_mask_t          isv;
  logic               valid_q;
  logic [IDX_W-1:0]   idx_q;
  lvl_t               lvl_q;

  assign ack_fire = valid_q & irq_ack;

  for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
    irq_ext_front u_front (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample_en (sample_en),
      .pin_n     (ext_pin_n[k]),
      .edge_mode (ext_edge_mode[k]),
      .ack_clr   (ack_fire && (idx_q == IDX_W'(k))),
      .req       (ext_req[k])
    );
  end

  assign cand = {int_req, ext_req} & src_en & {NUM_SRC{global_en}};

  irq_nest_tracker u_nest (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (ack_fire),
    .set_lvl (lvl_q),
    .clr_en  (reti),
    .isv     (isv),
    .any     (act_any),
    .top_lvl (act_lvl)
  );

  irq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .cand    (cand),
    .lvl_lo  (prio_lo),
    .lvl_hi  (prio_hi),
    .act_any (act_any),
    .act_lvl (act_lvl),
    .found   (found),
    .win_idx (win_idx),
    .win_lvl (win_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      lvl_q   <= '0;
    end else if (valid_q) begin
      if (irq_ack) valid_q <= 1'b0;
    end else if (boundary && found) begin
      valid_q <= 1'b1;
      idx_q   <= win_idx;
      lvl_q   <= win_lvl;
    end
  end

  assign irq_valid  = valid_q;
  assign irq_idx    = idx_q;
  assign irq_level  = lvl_q;
  assign in_service = isv;

  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !irq_ack |=> irq_valid && $stable(irq_idx) && $stable(irq_level)); // R10
  AST_GRANT_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> $past(boundary) && $past(global_en)); // R2
  AST_ABOVE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (in_service >> irq_level) == 4'd0); // R5
  AST_TOP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    in_service[3] |-> !irq_valid); // R6
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_en = 0;
  logic [1:0] ext_pin_n = 2'b11;
  logic [1:0] ext_edge_mode = 2'b00;
  logic [10:0] int_req = '0;
  logic global_en = 0;
  logic [12:0] src_en = '0, prio_lo = '0, prio_hi = '0;
  logic boundary = 0, irq_ack = 0, reti = 0;
  logic irq_valid;
  logic [3:0] irq_idx;
  logic [1:0] irq_level;
  logic [3:0] in_service;
  int checks = 0, errors = 0;
  logic [3:0] m_isv = '0;

  always #10 clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .ext_pin_n(ext_pin_n),
    .ext_edge_mode(ext_edge_mode), .int_req(int_req), .global_en(global_en),
    .src_en(src_en), .prio_lo(prio_lo), .prio_hi(prio_hi), .boundary(boundary),
    .irq_valid(irq_valid), .irq_idx(irq_idx), .irq_level(irq_level),
    .irq_ack(irq_ack), .reti(reti), .in_service(in_service));

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int model_pick(input logic [12:0] c, input logic [3:0] isv);
    int top = -1, best = -1, bl = -1;
    for (int l = 0; l < 4; l++) if (isv[l]) top = l;
    for (int i = 0; i < 13; i++) begin
      int lv = {prio_hi[i], prio_lo[i]};
      if (c[i] && lv > top && lv > bl) begin best = i; bl = lv; end
    end
    return best;
  endfunction

  function automatic logic [3:0] model_reti(input logic [3:0] isv);
    logic [3:0] r = isv;
    for (int l = 3; l >= 0; l--) if (r[l]) begin r[l] = 1'b0; break; end
    return r;
  endfunction

  task automatic bound();
    boundary = 1; tick(); boundary = 0;
  endtask

  task automatic ack(input logic with_reti);
    irq_ack = 1; reti = with_reti; tick(); irq_ack = 0; reti = 0;
  endtask

  task automatic do_reti();
    reti = 1; tick(); reti = 0;
  endtask

  task automatic set_lvl(input int s, input int l);
    prio_hi[s] = l[1]; prio_lo[s] = l[0];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    tick(); tick();
    chk("R1 valid after reset", irq_valid, 0);
    chk("R1 in_service after reset", in_service, 0);
    rst_n = 1; tick();

    // R2: global enable off masks everything
    src_en = '1; int_req = 11'h7ff; global_en = 0;
    bound(); chk("R2 global off", irq_valid, 0);
    // R2: per-source enable
    global_en = 1; int_req = 11'h008; src_en = '1; src_en[5] = 0;
    bound(); chk("R2 source disabled", irq_valid, 0);
    // R10: no boundary -> no grant
    src_en = '1; tick(); tick(); chk("R10 no boundary", irq_valid, 0);
    // R11/R3: internal bit 3 is source 5
    bound(); chk("R11 mapping valid", irq_valid, 1); chk("R11 mapping idx", irq_idx, 5);
    // R10: hold while not acknowledged
    int_req = 11'h001; set_lvl(2, 3); boundary = 1; tick(); tick(); boundary = 0;
    chk("R10 idx held", irq_idx, 5); chk("R10 valid held", irq_valid, 1);
    ack(0); chk("R10 valid drops after ack", irq_valid, 0);
    chk("R7 ack sets level0", in_service, 4'b0001);
    do_reti(); chk("R7 reti clears", in_service, 0);
    set_lvl(2, 0);

    // R3/R4 tie and level selection
    int_req = '0; int_req[2] = 1; int_req[6] = 1; int_req[8] = 1;   // sources 4,8,10
    set_lvl(4, 2); set_lvl(8, 2); set_lvl(10, 1);
    bound(); chk("R4 tie lowest index", irq_idx, 4); chk("R3 level", irq_level, 2);
    ack(0); chk("R7 set level2", in_service, 4'b0100);
    do_reti();

    // R5/R6 nesting
    prio_lo = '0; prio_hi = '0;
    set_lvl(5, 1); set_lvl(7, 1); set_lvl(9, 2); set_lvl(10, 3); set_lvl(3, 3);
    int_req = '0; int_req[3] = 1; bound(); chk("R3 grant lvl1", irq_idx, 5); ack(0);
    int_req = '0; int_req[5] = 1; bound(); chk("R5 equal level waits", irq_valid, 0);
    int_req[7] = 1; bound(); chk("R5 higher preempts", irq_idx, 9);
    // R7: ack and reti in the same cycle: 0010 -> clear bit1, set bit2 -> 0100
    ack(1); chk("R7 ack with reti", in_service, 4'b0100);
    int_req = '0; int_req[8] = 1; bound(); chk("R3 level3 grant", irq_idx, 10); ack(0);
    chk("R7 nested mask", in_service, 4'b1100);
    int_req[1] = 1; int_req[7] = 1; bound(); chk("R6 top level blocks", irq_valid, 0);
    do_reti(); chk("R7 reti clears highest", in_service, 4'b0100);
    do_reti(); chk("R7 reti empty", in_service, 0);
    int_req = '0; prio_lo = '0; prio_hi = '0;

    // R8 edge mode on pin 0
    ext_edge_mode = 2'b01;
    sample_en = 1; ext_pin_n = 2'b11; tick(); ext_pin_n = 2'b10; tick(); sample_en = 0;
    bound(); chk("R8 edge grants", irq_valid, 1); chk("R8 edge idx", irq_idx, 0);
    sample_en = 1; ext_pin_n = 2'b11; tick();
    ext_pin_n = 2'b10; ack(0); sample_en = 0;
    do_reti();
    bound(); chk("R8 edge at ack kept", irq_valid, 1); chk("R8 kept idx", irq_idx, 0);
    ack(0); do_reti();
    bound(); chk("R8 ack clears flag", irq_valid, 0);

    // R9 level mode on pin 1
    ext_edge_mode = 2'b00; sample_en = 1; ext_pin_n = 2'b01; tick(); sample_en = 0;
    bound(); chk("R9 level grants", irq_idx, 1); chk("R9 level valid", irq_valid, 1);
    ack(0); do_reti();
    bound(); chk("R9 not cleared by ack", irq_valid, 1); ack(0); do_reti();
    sample_en = 1; ext_pin_n = 2'b11; tick(); sample_en = 0;
    bound(); chk("R9 released", irq_valid, 0);

    // Random phase against the model (R2..R7)
    m_isv = in_service;
    for (int it = 0; it < 400; it++) begin
      int e;
      logic [12:0] c;
      global_en = ($urandom % 8) != 0;
      src_en = 13'($urandom); prio_lo = 13'($urandom); prio_hi = 13'($urandom);
      int_req = 11'($urandom) & 11'($urandom);
      c = {int_req, 2'b00} & src_en & {13{global_en}};
      e = model_pick(c, m_isv);
      bound();
      chk("R3 random valid", irq_valid, (e >= 0) ? 1 : 0);
      if (e >= 0) begin
        logic r;
        chk("R4 random idx", irq_idx, e);
        chk("R3 random level", irq_level, {prio_hi[e], prio_lo[e]});
        r = (m_isv != 0) && ($urandom % 3 == 0);
        ack(r);
        if (r) m_isv = model_reti(m_isv);
        m_isv[{prio_hi[e], prio_lo[e]}] = 1'b1;
        chk("R7 random mask", in_service, m_isv);
      end else if (m_isv != 0 && ($urandom % 2 == 0)) begin
        do_reti(); m_isv = model_reti(m_isv);
        chk("R7 random reti", in_service, m_isv);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule